// File: doc/BRIEF.md
# SPI user-command transfer engine

This block is a register-programmed SPI master that moves one chunk of serial data for each command. Software writes up to 64 bytes into a word-addressed data buffer over a simple register bus and programs the chunk length as a bit count. It then issues a go command. The engine drives chip select and the serial clock. It shifts the buffer out MSB first, starting with byte 0, and can capture the input line back into the same buffer positions. When the last bit has gone out, a sticky done flag is raised for software to poll and clear.

Transfers longer than the buffer are split by software into chunks that are started one after another. A hold-select control keeps chip select asserted between chunks so that they form one frame on the wire. Chip-select polarity and the idle clock level can be programmed. Data moves on single lines with clock phase 0: the output changes on the trailing clock edge and the input is sampled on the leading edge. A software reset bit returns the engine and its configuration to the power-up state.

Top module: `spi_uc_engine`

## Requirements
- R1: After reset, chip select is inactive (pin high), the serial clock and data output are low, and every control register reads 0.
- R2: Buffer word w is at bus word address 16+w. Chunk byte k is held in word k/4 at bits 8*(k mod 4)+7 down to 8*(k mod 4), and a buffer word reads back the value last written to it.
- R3: Writing 1 to bit 18 of the command register (address 0) while the engine is idle starts a chunk. The chunk produces exactly N+1 leading clock edges, where N is the 9-bit field at bits 25:17 of the length register (address 2). Bit 18 of the command register reads 1 while a chunk is in progress.
- R4: The output line carries byte 0 first and MSB first within each byte. The first bit is valid before the first leading edge, and the line changes only on trailing edges.
- R5: When bit 0 of the config register (address 1) is set, the input level at each leading edge replaces the buffer bit that was sent in that bit slot. When bit 0 is clear, the buffer is left unchanged.
- R6: Bit 4 of the status register (address 4) goes to 1 when a chunk completes and stays at 1 until software writes 0 to it.
- R7: At the end of a chunk, chip select is released unless bit 30 of the select register (address 3) is set. When that bit is set, chip select stays asserted into the next chunk.
- R8: Bit 23 of the select register makes chip select active high. Bit 7 of the config register makes the idle clock level high.
- R9: A go command written while a chunk is in progress is ignored. The chunk runs to its original length, even if the length register has been rewritten in the meantime.
- R10: While bit 30 of the status register is 1 (non-master mode), a go command starts nothing.
- R11: Writing 1 to bit 31 of the status register aborts any chunk, releases chip select, stops the clock, and clears all control registers. The bit itself reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Word address: control registers 0..4, buffer words 16..31 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select, polarity programmable |

## Verification
The shifter is tried with four chunk patterns. A 4-byte chunk with capture off checks edge counting and shows that an idle input leaves the buffer alone. A full 64-byte chunk with capture on shows whether in-place overwrite corrupts bits that have not yet been sent. A 2-byte chunk with hold-select followed by a 1-byte chunk without it separates frame continuation from release. A 1-byte chunk with both polarities inverted checks the pin encodings. Interfering commands cover the remaining cases: a second go with a shortened length mid-chunk, a go in non-master mode, and a software reset mid-chunk. These separate latching the length at start from reading it live, and an abort from a normal finish.

// File: rtl/spi_uc_pkg.sv
package spi_uc_pkg;

  // control register word addresses
  localparam int REG_CMD  = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_LEN  = 2;
  localparam int REG_CSC  = 3;
  localparam int REG_STAT = 4;

  // field positions
  localparam int CMD_GO    = 18;
  localparam int CFG_RXEN  = 0;
  localparam int CFG_CPOL  = 7;
  localparam int LEN_LSB   = 17;
  localparam int CSC_CSHI  = 23;
  localparam int CSC_KEEP  = 30;
  localparam int STAT_DONE = 4;
  localparam int STAT_SLV  = 30;
  localparam int STAT_SRST = 31;

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_e;

  typedef struct packed {
    logic rx_en;
    logic cpol;
    logic cs_high;
    logic keep_cs;
  } cfg_t;

endpackage

// File: rtl/spi_uc_regs.sv
module spi_uc_regs
  import spi_uc_pkg::*;
#(
  parameter int AW   = 5,
  parameter int BITW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            done_set_i,
  input  logic            busy_i,
  output cfg_t            cfg_o,
  output logic [BITW-1:0] len_o,
  output logic            start_o,
  output logic            srst_o,
  output logic [31:0]     rdata_o
);

  cfg_t            cfg_q, cfg_d;
  logic [BITW-1:0] len_q, len_d;
  logic            done_q, done_d;
  logic            slv_q, slv_d;
  logic            wr_cmd, wr_cfg, wr_len, wr_csc, wr_stat, upd;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign wr_cmd  = wr_i && (addr_i == AW'(REG_CMD));
  assign wr_cfg  = wr_i && (addr_i == AW'(REG_CFG));
  assign wr_len  = wr_i && (addr_i == AW'(REG_LEN));
  assign wr_csc  = wr_i && (addr_i == AW'(REG_CSC));
  assign wr_stat = wr_i && (addr_i == AW'(REG_STAT));

  assign srst_o  = wr_stat && wdata_i[STAT_SRST];
  assign start_o = wr_cmd && wdata_i[CMD_GO] && !slv_q && !srst_o;
  assign upd     = wr_cfg || wr_len || wr_csc || wr_stat || done_set_i;

  always_comb begin
    cfg_d  = cfg_q;
    len_d  = len_q;
    done_d = done_q;
    slv_d  = slv_q;
    if (srst_o) begin
      cfg_d  = '0;
      len_d  = '0;
      done_d = 1'b0;
      slv_d  = 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_d.rx_en = wdata_i[CFG_RXEN];
        cfg_d.cpol  = wdata_i[CFG_CPOL];
      end
      if (wr_len) len_d = wdata_i[LEN_LSB +: BITW];
      if (wr_csc) begin
        cfg_d.cs_high = wdata_i[CSC_CSHI];
        cfg_d.keep_cs = wdata_i[CSC_KEEP];
      end
      if (wr_stat) begin
        done_d = wdata_i[STAT_DONE];
        slv_d  = wdata_i[STAT_SLV];
      end
      if (done_set_i) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
      slv_q  <= 1'b0;
    end else if (upd) begin
      cfg_q  <= cfg_d;
      len_q  <= len_d;
      done_q <= done_d;
      slv_q  <= slv_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(REG_CMD):  rdata_o[CMD_GO] = busy_i;
      AW'(REG_CFG):  begin
        rdata_o[CFG_RXEN] = cfg_q.rx_en;
        rdata_o[CFG_CPOL] = cfg_q.cpol;
      end
      AW'(REG_LEN):  rdata_o[LEN_LSB +: BITW] = len_q;
      AW'(REG_CSC):  begin
        rdata_o[CSC_CSHI] = cfg_q.cs_high;
        rdata_o[CSC_KEEP] = cfg_q.keep_cs;
      end
      AW'(REG_STAT): begin
        rdata_o[STAT_DONE] = done_q;
        rdata_o[STAT_SLV]  = slv_q;
      end
      default:       rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign len_o = len_q;

  // R6: a completion always leaves the flag set
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_set_i |=> done_q);
  // R6: the flag only drops through a status write
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wr_stat) |=> done_q);
  // R10: non-master mode never lets a start through
  p_slave_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slv_q |-> !start_o);

endmodule

// File: rtl/spi_uc_buf.sv
module spi_uc_buf #(
  parameter int WORDS = 16,
  parameter int BITW  = 9,
  localparam int DW   = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int LW   = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [IW-1:0]   widx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [IW-1:0]   ridx_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [BITW-1:0] bit_rd_idx_i,
  output logic            bit_rd_o,
  input  logic            bit_wr_i,
  input  logic [BITW-1:0] bit_wr_idx_i,
  input  logic            bit_wr_val_i
);

  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] mem_d [WORDS];
  logic [WORDS-1:0] we;

  logic [IW-1:0] rd_word, wb_word;
  logic [LW-1:0] rd_pos, wb_pos;

  // serial bit i: byte i/8, MSB first inside the byte, bytes little-endian
  assign rd_word = bit_rd_idx_i[BITW-1:LW];
  assign rd_pos  = {bit_rd_idx_i[LW-1:3], ~bit_rd_idx_i[2:0]};
  assign wb_word = bit_wr_idx_i[BITW-1:LW];
  assign wb_pos  = {bit_wr_idx_i[LW-1:3], ~bit_wr_idx_i[2:0]};

  for (genvar w = 0; w < WORDS; w++) begin : g_we
    assign we[w] = (wr_i && (widx_i == IW'(w))) ||
                   (bit_wr_i && (wb_word == IW'(w)));
  end

  always_comb begin
    for (int w = 0; w < WORDS; w++) mem_d[w] = mem_q[w];
    if (wr_i) mem_d[widx_i] = wdata_i;
    if (bit_wr_i) mem_d[wb_word][wb_pos] = bit_wr_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++)
        if (we[w]) mem_q[w] <= mem_d[w];
    end
  end

  assign rdata_o  = mem_q[ridx_i];
  assign bit_rd_o = mem_q[rd_word][rd_pos];

endmodule

// File: rtl/spi_uc_shifter.sv
module spi_uc_shifter
  import spi_uc_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int BITW     = 9,
  localparam int CW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst_i,
  input  logic            start_i,
  input  logic [BITW-1:0] len_i,
  input  cfg_t            cfg_i,
  input  logic            miso_i,
  output logic [BITW-1:0] bit_rd_idx_o,
  input  logic            bit_rd_i,
  output logic            bit_wr_o,
  output logic [BITW-1:0] bit_wr_idx_o,
  output logic            bit_wr_val_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic            cs_o
);

  eng_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            phase_q, phase_d;
  logic [BITW-1:0] idx_q, idx_d;
  logic [BITW-1:0] last_q, last_d;
  logic            mosi_q, mosi_d;
  logic            cs_q, cs_d;
  logic            shifting, tick, lead, trail, at_last;

  assign shifting = (state_q == ST_SHIFT);
  assign tick     = shifting && (cnt_q == CW'(HALF_CYC - 1));
  assign lead     = tick && !phase_q;
  assign trail    = tick && phase_q;
  assign at_last  = (idx_q == last_q);

  // idle: first bit; shifting: the bit after the current one
  assign bit_rd_idx_o = shifting ? (idx_q + BITW'(1)) : '0;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    last_d  = last_q;
    mosi_d  = mosi_q;
    cs_d    = cs_q;
    if (srst_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      phase_d = 1'b0;
      idx_d   = '0;
      mosi_d  = 1'b0;
      cs_d    = 1'b0;
    end else if (!shifting) begin
      if (start_i) begin
        state_d = ST_SHIFT;
        cnt_d   = '0;
        phase_d = 1'b0;
        idx_d   = '0;
        last_d  = len_i;
        mosi_d  = bit_rd_i;
        cs_d    = 1'b1;
      end
    end else begin
      cnt_d = tick ? '0 : cnt_q + CW'(1);
      if (lead) phase_d = 1'b1;
      if (trail) begin
        phase_d = 1'b0;
        if (at_last) begin
          state_d = ST_IDLE;
          mosi_d  = 1'b0;
          cs_d    = cfg_i.keep_cs;
        end else begin
          idx_d  = idx_q + BITW'(1);
          mosi_d = bit_rd_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      mosi_q  <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      mosi_q  <= mosi_d;
      cs_q    <= cs_d;
    end
  end

  assign bit_wr_o     = lead && cfg_i.rx_en && !srst_i;
  assign bit_wr_idx_o = idx_q;
  assign bit_wr_val_o = miso_i;
  assign done_o       = trail && at_last && !srst_i;
  assign busy_o       = shifting;
  assign sclk_o       = phase_q ^ cfg_i.cpol;
  assign mosi_o       = mosi_q;
  assign cs_o         = cfg_i.cs_high ? cs_q : ~cs_q;

  // R7: select is held for the whole chunk
  p_cs_during_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> cs_q);
  // R8: clock rests at its idle level between chunks
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> !phase_q);
  // R4: data out moves only on a trailing edge
  p_mosi_trail_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && !trail && !srst_i) |=> $stable(mosi_q));
  // R3: the bit index never passes the programmed end
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> (idx_q <= last_q));
  // R9: a go during a chunk neither restarts it nor changes its length
  p_busy_go_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && start_i && !srst_i && idx_q != '0) |=> (idx_q != '0 && $stable(last_q)));

endmodule

// File: rtl/spi_uc_engine.sv
module spi_uc_engine
  import spi_uc_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int HALF_CYC  = 2,
  localparam int ADDR_W   = $clog2(BUF_BYTES / 4) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs
);

  localparam int WORDS = BUF_BYTES / 4;
  localparam int IW    = ADDR_W - 1;
  localparam int BITW  = $clog2(BUF_BYTES * 8);

  cfg_t            cfg;
  logic [BITW-1:0] len, rd_idx, wb_idx;
  logic            start, srst, busy, done, rd_bit, wb_en, wb_val;
  logic            buf_sel, buf_wr;
  logic [31:0]     reg_rdata, buf_rdata;

  assign buf_sel = bus_addr[ADDR_W-1];
  assign buf_wr  = bus_wr && buf_sel;

  spi_uc_regs #(.AW(ADDR_W), .BITW(BITW)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (bus_wr && !buf_sel),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .done_set_i (done),
    .busy_i     (busy),
    .cfg_o      (cfg),
    .len_o      (len),
    .start_o    (start),
    .srst_o     (srst),
    .rdata_o    (reg_rdata)
  );

  spi_uc_buf #(.WORDS(WORDS), .BITW(BITW)) buf_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (buf_wr),
    .widx_i       (bus_addr[IW-1:0]),
    .wdata_i      (bus_wdata),
    .ridx_i       (bus_addr[IW-1:0]),
    .rdata_o      (buf_rdata),
    .bit_rd_idx_i (rd_idx),
    .bit_rd_o     (rd_bit),
    .bit_wr_i     (wb_en),
    .bit_wr_idx_i (wb_idx),
    .bit_wr_val_i (wb_val)
  );

  spi_uc_shifter #(.HALF_CYC(HALF_CYC), .BITW(BITW)) shift_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .srst_i       (srst),
    .start_i      (start),
    .len_i        (len),
    .cfg_i        (cfg),
    .miso_i       (spi_miso),
    .bit_rd_idx_o (rd_idx),
    .bit_rd_i     (rd_bit),
    .bit_wr_o     (wb_en),
    .bit_wr_idx_o (wb_idx),
    .bit_wr_val_o (wb_val),
    .busy_o       (busy),
    .done_o       (done),
    .sclk_o       (spi_sclk),
    .mosi_o       (spi_mosi),
    .cs_o         (spi_cs)
  );

  assign bus_rdata = buf_sel ? buf_rdata : reg_rdata;

  // R11: a software reset leaves the engine idle on the next cycle
  p_srst_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !busy);

endmodule

// File: tb/spi_uc_engine_tb_top.sv
module spi_uc_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs;

  always #4 clk = ~clk;

  spi_uc_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] bufm [64];
  logic [7:0] mpat [64];
  logic [7:0] exp_q [$];
  int rbit = 0, edges = 0, mosi_viol = 0, shn = 0;
  logic [7:0] sh = '0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, cpol_tb = 1'b0, cshi_tb = 1'b0;

  assign spi_miso = (rbit < 512) ? mpat[rbit / 8][7 - (rbit % 8)] : 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: collect bytes at leading edges and compare to the queue (R4)
  always @(negedge clk) begin
    if (rst_n && (spi_cs == cshi_tb)) begin
      if (prev_sclk == cpol_tb && spi_sclk != cpol_tb) begin
        edges++;
        rbit++;
        sh = {sh[6:0], spi_mosi};
        shn++;
        if (shn == 8) begin
          shn = 0;
          if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected mosi byte", sh, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(sh == e, "R4", "mosi byte", sh, e);
          end
        end
      end
      if (prev_sclk != cpol_tb && spi_sclk != cpol_tb && spi_mosi != prev_mosi)
        mosi_viol++;
    end
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] word_of(input int w);
    return {bufm[4*w+3], bufm[4*w+2], bufm[4*w+1], bufm[4*w]};
  endfunction

  task automatic load_buffer();
    for (int w = 0; w < 16; w++) bus_write(16 + w, word_of(w));
  endtask

  // driver: program a chunk and push its expected output bytes
  task automatic go_chunk(input int nbytes, input bit rx, input bit keep,
                          input bit cpol, input bit cshi);
    for (int k = 0; k < nbytes; k++) exp_q.push_back(bufm[k]);
    bus_write(1, (32'(cpol) << 7) | 32'(rx));
    bus_write(3, (32'(keep) << 30) | (32'(cshi) << 23));
    cpol_tb = cpol; cshi_tb = cshi;
    bus_write(2, 32'(nbytes * 8 - 1) << 17);
    bus_write(4, 32'h0);
    rbit = 0; edges = 0; mosi_viol = 0;
    bus_write(0, 32'h1 << 18);
  endtask

  task automatic wait_done(input string req);
    logic [31:0] d;
    bit seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      bus_read(4, d);
      seen = d[4];
    end
    chk(seen, req, "done flag after chunk", seen, 1);
  endtask

  task automatic check_buffer(input string req);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      bus_read(16 + w, d);
      chk(d == word_of(w), req, $sformatf("buffer word %0d", w), d, word_of(w));
    end
  endtask

  initial begin
    logic [31:0] d;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 64; i++) begin
      bufm[i] = 8'(i * 11 + 3);
      mpat[i] = 8'(i * 37 + 5) ^ 8'hA5;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(spi_cs == 1'b1, "R1", "cs after reset", spi_cs, 1);
    chk(spi_sclk == 1'b0, "R1", "sclk after reset", spi_sclk, 0);
    chk(spi_mosi == 1'b0, "R1", "mosi after reset", spi_mosi, 0);
    for (int a = 0; a < 5; a++) begin
      bus_read(a, d);
      chk(d == 0, "R1", $sformatf("register %0d after reset", a), d, 0);
    end

    // R2 buffer packing and read-back
    load_buffer();
    check_buffer("R2");

    // chunk A: 4 bytes, capture off
    go_chunk(4, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    bus_read(0, d);
    chk(d[18] == 1'b1, "R3", "busy bit during chunk", d[18], 1);
    wait_done("R6");
    repeat (4) @(negedge clk);
    chk(edges == 32, "R3", "leading edges for 4 bytes", edges, 32);
    chk(exp_q.size() == 0, "R3", "bytes left in queue", exp_q.size(), 0);
    chk(mosi_viol == 0, "R4", "mosi moved while clock active", mosi_viol, 0);
    chk(spi_cs == 1'b1, "R7", "cs released after chunk", spi_cs, 1);
    check_buffer("R5");
    repeat (30) @(negedge clk);
    bus_read(4, d);
    chk(d[4] == 1'b1, "R6", "done flag sticky", d[4], 1);
    bus_write(4, 32'h0);
    bus_read(4, d);
    chk(d[4] == 1'b0, "R6", "done flag cleared by write", d[4], 0);

    // chunk B: full buffer, capture on
    go_chunk(64, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_done("R3");
    repeat (4) @(negedge clk);
    chk(edges == 512, "R3", "leading edges for 64 bytes", edges, 512);
    chk(mosi_viol == 0, "R4", "mosi stable while clock active", mosi_viol, 0);
    for (int k = 0; k < 64; k++) bufm[k] = mpat[k];
    check_buffer("R5");

    // hold-select across chunks
    for (int i = 0; i < 64; i++) bufm[i] = 8'(i * 29 + 17);
    load_buffer();
    go_chunk(2, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_done("R7");
    repeat (4) @(negedge clk);
    chk(spi_cs == 1'b0, "R7", "cs held after keep chunk", spi_cs, 0);
    go_chunk(1, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_done("R7");
    repeat (4) @(negedge clk);
    chk(spi_cs == 1'b1, "R7", "cs released after last chunk", spi_cs, 1);
    chk(edges == 8, "R7", "edges in second chunk", edges, 8);

    // polarities
    bus_write(3, 32'h1 << 23);
    bus_write(1, 32'h1 << 7);
    cpol_tb = 1'b1; cshi_tb = 1'b1;
    #1;
    chk(spi_sclk == 1'b1, "R8", "idle sclk high", spi_sclk, 1);
    chk(spi_cs == 1'b0, "R8", "idle cs low when active high", spi_cs, 0);
    go_chunk(1, 1'b0, 1'b0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    chk(spi_cs == 1'b1, "R8", "cs high during chunk", spi_cs, 1);
    wait_done("R8");
    repeat (4) @(negedge clk);
    chk(edges == 8, "R8", "edges with inverted clock", edges, 8);
    chk(spi_sclk == 1'b1 && spi_cs == 1'b0, "R8", "idle levels after chunk",
        {spi_sclk, spi_cs}, 2'b10);

    // go while busy
    go_chunk(8, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    bus_write(2, 32'd7 << 17);
    bus_write(0, 32'h1 << 18);
    wait_done("R9");
    repeat (4) @(negedge clk);
    chk(edges == 64, "R9", "chunk length kept", edges, 64);
    chk(exp_q.size() == 0, "R9", "all bytes sent", exp_q.size(), 0);

    // non-master mode blocks go
    bus_write(4, 32'h1 << 30);
    edges = 0;
    bus_write(0, 32'h1 << 18);
    repeat (40) @(negedge clk);
    chk(edges == 0, "R10", "no edges in non-master mode", edges, 0);
    bus_read(4, d);
    chk(d == (32'h1 << 30), "R10", "status in non-master mode", d, 32'h1 << 30);
    chk(spi_cs == 1'b1, "R10", "cs inactive", spi_cs, 1);
    bus_write(4, 32'h0);

    // software reset mid-chunk
    go_chunk(8, 1'b1, 1'b1, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    bus_write(4, 32'h1 << 31);
    cpol_tb = 1'b0; cshi_tb = 1'b0;
    exp_q.delete(); shn = 0;
    #1;
    chk(spi_cs == 1'b1, "R11", "cs released by soft reset", spi_cs, 1);
    chk(spi_sclk == 1'b0, "R11", "sclk idle after soft reset", spi_sclk, 0);
    for (int a = 0; a < 5; a++) begin
      bus_read(a, d);
      chk(d == 0, "R11", $sformatf("register %0d after soft reset", a), d, 0);
    end
    edges = 0;
    repeat (60) @(negedge clk);
    chk(edges == 0, "R11", "no edges after soft reset", edges, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule